// File: doc/BRIEF.md
# Ternary Match Table with Staged Command Engine

This block is a small ternary match table that is never written directly. Software fills a register-mapped staging cache (key words, care-mask words, a type-group word, action words and counter words). It then issues a one-shot command through a control register. A sequencer carries out the command by copying between the cache and the table, one row per clock. The control register carries a command code, a row address, three section-disable bits and a start bit that clears itself. Commands are single-row write and read, block move toward lower or higher addresses, and fill of a row range.

A lookup port runs at the same time as the sequencer. It compares a presented key against every row and returns the action of the winning row. Each lookup hit also counts up that row's counter.

Top module: `tcam_cache_engine`

## Requirements
- R1: After reset every cache register, the control register, the move-count register and every table row read as zero, and any lookup reports a miss.
- R2: Register map, addressed by `reg_addr[7:4]` region and `reg_addr[3:0]` word: 0 key, 1 mask, 2 type-group, 3 action, 4 counter, 5 control, 6 move count. A mask bit of 1 means the key bit is ignored (don't care). A mask bit of 0 means the key bit must match.
- R3: Control layout: `[2:0]` command, `[4]` key/mask/type-group disable, `[5]` action disable, `[6]` counter disable, `[15:8]` row, `[31]` start. Command 0 copies the enabled cache parts into the row. Command 1 copies the enabled parts of the row into the cache.
- R4: The start bit reads 1 while a command runs. Read and write take exactly 1 cycle. Move and fill take N cycles for a move count N, and 1 cycle when N is 0. A start written while a command runs is ignored.
- R5: A command with the key part enabled and a row of ROWS or more is ignored: the start bit never reads 1 and no row changes.
- R6: Move up (code 2) copies rows row..row+N-1, in ascending order, each to the address one lower. Copies whose source or destination falls outside the table are skipped. The last source row keeps its contents.
- R7: Move down (code 3) copies rows row+N-1 down to row, each to the address one higher. Out-of-range copies are skipped, and the lowest source row keeps its contents.
- R8: Fill (code 4) writes the enabled cache parts into rows row..row+N-1. Rows past the end of the table are skipped, but they still take a cycle each.
- R9: A set disable bit leaves that part of the row (for write, move and fill) or of the cache (for read) unchanged.
- R10: A row hits when its type-group word is non-zero and `((key ^ row_key) & ~row_mask)` is zero. Among hitting rows, the highest address wins, and `lk_action` carries its action.
- R11: With `lk_valid` high and no hitting row, `lk_miss` is 1, `lk_hit` is 0 and `lk_action` is zero.
- R12: Each clock with a lookup hit increments the winning row's counter by one. If a command writes that row's counter in the same clock, the command's value is kept and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address (region, word) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | 32*KEY_WORDS | Lookup key |
| lk_hit | output | 1 | Lookup found a row |
| lk_miss | output | 1 | Lookup found no row |
| lk_action | output | 32*ACT_WORDS | Action of the winning row, zero on miss |

## Verification
Two functions can act on the same counter in the same clock: a lookup hit incrementing the row's counter, and a write command storing a new counter value into that row. The bench accepts a counter-only write to a row and presents that row's key on the lookup port during the exact cycle in which the command executes. It then reads the counter back through a read command and expects the written value, not the written value plus one. A later idle lookup must then add exactly one.

// File: rtl/tcam_cache_engine.sv
module tcam_cache_engine #(
  parameter int ROWS      = 16,
  parameter int KEY_WORDS = 2,
  parameter int ACT_WORDS = 1,
  parameter int CNT_WORDS = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [7:0]                reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  input  logic                      lk_valid,
  input  logic [32*KEY_WORDS-1:0]   lk_key,
  output logic                      lk_hit,
  output logic                      lk_miss,
  output logic [32*ACT_WORDS-1:0]   lk_action
);
  localparam int KW  = 32 * KEY_WORDS;
  localparam int AW  = 32 * ACT_WORDS;
  localparam int CW  = 32 * CNT_WORDS;
  localparam int RIX = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int PW  = 25;

  localparam logic [2:0] C_WR = 3'd0, C_RD = 3'd1, C_UP = 3'd2, C_DN = 3'd3, C_FILL = 3'd4;

  logic [KW-1:0] key_mem [ROWS];
  logic [KW-1:0] msk_mem [ROWS];
  logic [31:0]   tg_mem  [ROWS];
  logic [AW-1:0] act_mem [ROWS];
  logic [CW-1:0] cnt_mem [ROWS];

  logic [KW-1:0] c_key, c_msk;
  logic [31:0]   c_tg;
  logic [AW-1:0] c_act;
  logic [CW-1:0] c_cnt;

  logic [2:0]  op_cmd, op_dis;
  logic [7:0]  op_row;
  logic [15:0] mv_cnt, rem;
  logic        busy;
  logic [PW-1:0] ptr, dst;

  wire [3:0] region = reg_addr[7:4];
  wire [3:0] widx   = reg_addr[3:0];

  wire ctl_wr = reg_we && (region == 4'd5);
  wire go     = ctl_wr && reg_wdata[31] && !busy;
  wire bad    = !reg_wdata[4] && (32'(reg_wdata[15:8]) >= 32'(ROWS));
  wire single = (reg_wdata[2:0] == C_WR) || (reg_wdata[2:0] == C_RD);
  wire do_op  = busy && (rem != 16'd0);

  always_comb begin
    case (op_cmd)
      C_UP:    dst = ptr - PW'(1);
      C_DN:    dst = ptr + PW'(1);
      default: dst = ptr;
    endcase
  end
  wire src_ok = 32'(ptr) < 32'(ROWS);
  wire dst_ok = 32'(dst) < 32'(ROWS);
  wire [RIX-1:0] s_ix = ptr[RIX-1:0];
  wire [RIX-1:0] d_ix = dst[RIX-1:0];

  logic           hit_any;
  logic [RIX-1:0] win;
  always_comb begin
    hit_any = 1'b0;
    win     = '0;
    for (int r = 0; r < ROWS; r++)
      if (tg_mem[r] != 32'd0 && ((lk_key ^ key_mem[r]) & ~msk_mem[r]) == '0) begin
        hit_any = 1'b1;
        win     = RIX'(r);
      end
  end
  assign lk_hit    = lk_valid && hit_any;
  assign lk_miss   = lk_valid && !hit_any;
  assign lk_action = lk_hit ? act_mem[win] : '0;

  always_comb begin
    reg_rdata = '0;
    case (region)
      4'd0: for (int w = 0; w < KEY_WORDS; w++) if (32'(widx) == w) reg_rdata = c_key[w*32 +: 32];
      4'd1: for (int w = 0; w < KEY_WORDS; w++) if (32'(widx) == w) reg_rdata = c_msk[w*32 +: 32];
      4'd2: reg_rdata = c_tg;
      4'd3: for (int w = 0; w < ACT_WORDS; w++) if (32'(widx) == w) reg_rdata = c_act[w*32 +: 32];
      4'd4: for (int w = 0; w < CNT_WORDS; w++) if (32'(widx) == w) reg_rdata = c_cnt[w*32 +: 32];
      4'd5: reg_rdata = {busy, 15'd0, op_row, 1'b0, op_dis, 1'b0, op_cmd};
      4'd6: reg_rdata = {16'd0, mv_cnt};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        key_mem[r] <= '0; msk_mem[r] <= '0; tg_mem[r] <= '0;
        act_mem[r] <= '0; cnt_mem[r] <= '0;
      end
      c_key <= '0; c_msk <= '0; c_tg <= '0; c_act <= '0; c_cnt <= '0;
      op_cmd <= '0; op_dis <= '0; op_row <= '0; mv_cnt <= '0;
      rem <= '0; busy <= 1'b0; ptr <= '0;
    end else begin
      if (lk_hit) cnt_mem[win] <= cnt_mem[win] + CW'(1);

      if (reg_we) begin
        case (region)
          4'd0: for (int w = 0; w < KEY_WORDS; w++) if (32'(widx) == w) c_key[w*32 +: 32] <= reg_wdata;
          4'd1: for (int w = 0; w < KEY_WORDS; w++) if (32'(widx) == w) c_msk[w*32 +: 32] <= reg_wdata;
          4'd2: c_tg <= reg_wdata;
          4'd3: for (int w = 0; w < ACT_WORDS; w++) if (32'(widx) == w) c_act[w*32 +: 32] <= reg_wdata;
          4'd4: for (int w = 0; w < CNT_WORDS; w++) if (32'(widx) == w) c_cnt[w*32 +: 32] <= reg_wdata;
          4'd6: mv_cnt <= reg_wdata[15:0];
          default: ;
        endcase
      end

      if (go) begin
        op_cmd <= reg_wdata[2:0];
        op_dis <= reg_wdata[6:4];
        op_row <= reg_wdata[15:8];
        if (!bad) begin
          busy <= 1'b1;
          rem  <= single ? 16'd1 : mv_cnt;
          ptr  <= (reg_wdata[2:0] == C_DN) ? PW'(reg_wdata[15:8]) + PW'(mv_cnt) - PW'(1)
                                           : PW'(reg_wdata[15:8]);
        end
      end

      if (busy && rem <= 16'd1) busy <= 1'b0;

      if (do_op) begin
        rem <= rem - 16'd1;
        ptr <= (op_cmd == C_DN) ? ptr - PW'(1) : ptr + PW'(1);
        case (op_cmd)
          C_WR, C_FILL: if (dst_ok) begin
            if (!op_dis[0]) begin key_mem[d_ix] <= c_key; msk_mem[d_ix] <= c_msk; tg_mem[d_ix] <= c_tg; end
            if (!op_dis[1]) act_mem[d_ix] <= c_act;
            if (!op_dis[2]) cnt_mem[d_ix] <= c_cnt;
          end
          C_RD: if (src_ok) begin
            if (!op_dis[0]) begin c_key <= key_mem[s_ix]; c_msk <= msk_mem[s_ix]; c_tg <= tg_mem[s_ix]; end
            if (!op_dis[1]) c_act <= act_mem[s_ix];
            if (!op_dis[2]) c_cnt <= cnt_mem[s_ix];
          end
          C_UP, C_DN: if (src_ok && dst_ok) begin
            if (!op_dis[0]) begin
              key_mem[d_ix] <= key_mem[s_ix]; msk_mem[d_ix] <= msk_mem[s_ix]; tg_mem[d_ix] <= tg_mem[s_ix];
            end
            if (!op_dis[1]) act_mem[d_ix] <= act_mem[s_ix];
            if (!op_dis[2]) cnt_mem[d_ix] <= cnt_mem[s_ix];
          end
          default: ;
        endcase
      end
    end
  end

  a_r5_bad_row_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    go && bad |=> !busy);

  a_r4_single_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    go && !bad && single |=> busy ##1 !busy);

  a_r4_start_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rem <= 16'd1 |=> !busy);

  a_r12_hit_counts: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit && !busy |=> cnt_mem[$past(win)] == $past(cnt_mem[win]) + CW'(1));

  a_r10_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> tg_mem[win] != 32'd0);
endmodule

// File: tb/test_tcam_cache_engine.sv
module test_tcam_cache_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic lk_valid = 1'b0;
  logic [63:0] lk_key = '0;
  logic lk_hit, lk_miss;
  logic [31:0] lk_action;

  tcam_cache_engine i_tcam_cache_engine (.*);

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  logic [63:0] mk [16], mm [16];
  logic [31:0] mt [16], ma [16], mc [16];
  logic [63:0] ck, cm;
  logic [31:0] ct, ca, cc;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl(input logic [2:0] c, input logic [2:0] d, input logic [7:0] row);
    return {1'b1, 15'd0, row, 1'b0, d, 1'b0, c};
  endfunction

  task automatic load(input logic [63:0] k, input logic [63:0] m, input logic [31:0] t,
                      input logic [31:0] a, input logic [31:0] c);
    wr(8'h00, k[31:0]); wr(8'h01, k[63:32]); wr(8'h10, m[31:0]); wr(8'h11, m[63:32]);
    wr(8'h20, t); wr(8'h30, a); wr(8'h40, c);
    ck = k; cm = m; ct = t; ca = a; cc = c;
  endtask

  task automatic cpy(input int d, input int s, input logic [2:0] dis);
    if (!dis[0]) begin mk[d] = mk[s]; mm[d] = mm[s]; mt[d] = mt[s]; end
    if (!dis[1]) ma[d] = ma[s];
    if (!dis[2]) mc[d] = mc[s];
  endtask

  task automatic put(input int d, input logic [2:0] dis);
    if (!dis[0]) begin mk[d] = ck; mm[d] = cm; mt[d] = ct; end
    if (!dis[1]) ma[d] = ca;
    if (!dis[2]) mc[d] = cc;
  endtask

  task automatic do_cmd(input logic [2:0] c, input logic [2:0] dis, input int row, input int n, input string tag);
    int cyc = 0, expc;
    logic [31:0] v;
    bit bad = !dis[0] && row >= 16;
    if (c > 3'd1) wr(8'h60, n);
    wr(8'h50, ctl(c, dis, row[7:0]));
    rd(8'h50, v);
    while (v[31] && cyc < 1000) begin cyc++; @(negedge clk); rd(8'h50, v); end
    expc = bad ? 0 : (c <= 3'd1) ? 1 : (n == 0) ? 1 : n;
    chk(cyc == expc, {tag, " R4 busy cycles"}, cyc, expc);
    if (!bad) begin
      case (c)
        3'd0: if (row < 16) put(row, dis);
        3'd1: if (row < 16) begin
          if (!dis[0]) begin ck = mk[row]; cm = mm[row]; ct = mt[row]; end
          if (!dis[1]) ca = ma[row];
          if (!dis[2]) cc = mc[row];
        end
        3'd2: for (int i = 0; i < n; i++) if (row + i < 16 && row + i >= 1) cpy(row + i - 1, row + i, dis);
        3'd3: for (int i = n - 1; i >= 0; i--) if (row + i + 1 < 16) cpy(row + i + 1, row + i, dis);
        3'd4: for (int i = 0; i < n; i++) if (row + i < 16) put(row + i, dis);
        default: ;
      endcase
    end
  endtask

  task automatic look(input logic [63:0] key, input string tag);
    bit h = 1'b0;
    int w = 0;
    @(negedge clk); lk_valid = 1'b1; lk_key = key; #1;
    for (int r = 0; r < 16; r++)
      if (mt[r] != 0 && ((key ^ mk[r]) & ~mm[r]) == 64'd0) begin h = 1'b1; w = r; end
    chk(lk_hit == h && lk_miss == !h, {tag, " R10 R11 hit/miss"}, {lk_hit, lk_miss}, {h, !h});
    chk(lk_action == (h ? ma[w] : 32'd0), {tag, " R10 R11 action"}, lk_action, h ? ma[w] : 32'd0);
    @(negedge clk); lk_valid = 1'b0;
    if (h) mc[w] = mc[w] + 1;
  endtask

  task automatic verify_all(input string tag);
    logic [31:0] v;
    for (int r = 0; r < 16; r++) begin
      do_cmd(3'd1, 3'd0, r, 0, tag);
      rd(8'h00, v); chk(v == ck[31:0],  {tag, " R3 key0"}, v, ck[31:0]);
      rd(8'h01, v); chk(v == ck[63:32], {tag, " R3 key1"}, v, ck[63:32]);
      rd(8'h10, v); chk(v == cm[31:0],  {tag, " R2 mask0"}, v, cm[31:0]);
      rd(8'h11, v); chk(v == cm[63:32], {tag, " R2 mask1"}, v, cm[63:32]);
      rd(8'h20, v); chk(v == ct, {tag, " R3 tg"}, v, ct);
      rd(8'h30, v); chk(v == ca, {tag, " R3 action"}, v, ca);
      rd(8'h40, v); chk(v == cc, {tag, " R12 counter"}, v, cc);
    end
  endtask

  function automatic logic [63:0] rkey(input int r);
    return {32'hCAFE_0000 | 32'(r), 32'h0000_0100 + 32'(r)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int r = 0; r < 16; r++) begin mk[r] = 0; mm[r] = 0; mt[r] = 0; ma[r] = 0; mc[r] = 0; end
    ck = 0; cm = 0; ct = 0; ca = 0; cc = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h50, v); chk(v == 0, "R1 control", v, 0);
    rd(8'h60, v); chk(v == 0, "R1 move count", v, 0);
    rd(8'h00, v); chk(v == 0, "R1 cache key", v, 0);
    look(64'd0, "R1 reset lookup");
    verify_all("R1 table");

    // R3 fill table; row 15 left with zero type-group
    for (int r = 0; r < 16; r++) begin
      load(rkey(r), 64'd0, (r == 15) ? 32'd0 : 32'd1, 32'hAC00_0000 + 32'(r), 32'd0);
      do_cmd(3'd0, 3'd0, r, 0, "R3 write");
    end
    for (int p = 0; p < 2; p++) for (int r = 0; r < 16; r++) look(rkey(r), "R10 sweep");
    look(64'hDEAD_BEEF_0000_0000, "R11 foreign key");

    // R2 partial care mask on row 6
    load(rkey(6), 64'h0000_0000_0000_00FF, 32'd1, 32'hAC00_0006, 32'd0);
    do_cmd(3'd0, 3'd0, 6, 0, "R2 mask write");
    look(rkey(6) ^ 64'h5A, "R2 dont-care bits");
    look(rkey(6) ^ 64'h100, "R2 care bit differs");
    verify_all("R3 readback");

    // R9 section disables
    load(64'h1234_5678_9ABC_DEF0, 64'd0, 32'd1, 32'h5555_5555, 32'd99);
    do_cmd(3'd0, 3'b110, 2, 0, "R9 key only");
    look(64'h1234_5678_9ABC_DEF0, "R9 action kept");
    wr(8'h40, 32'd77); cc = 32'd77;
    do_cmd(3'd0, 3'b011, 3, 0, "R9 counter only");
    load(64'h0, 64'h0, 32'h0, 32'h0, 32'h0);
    do_cmd(3'd1, 3'b101, 9, 0, "R9 read action only");
    rd(8'h30, v); chk(v == ma[9], "R9 cache action", v, ma[9]);
    rd(8'h00, v); chk(v == 0, "R9 cache key untouched", v, 0);

    // R12 same-cycle lookup hit and counter write on row 7
    wr(8'h40, 32'd500); cc = 32'd500;
    @(negedge clk); reg_we = 1'b1; reg_addr = 8'h50; reg_wdata = ctl(3'd0, 3'b011, 8'd7);
    @(negedge clk); reg_we = 1'b0; lk_valid = 1'b1; lk_key = rkey(7); #1;
    chk(lk_hit && lk_action == ma[7], "R12 conflict lookup", lk_action, ma[7]);
    @(negedge clk); lk_valid = 1'b0;
    mc[7] = 32'd500;
    do_cmd(3'd1, 3'b011, 7, 0, "R12 read counter");
    rd(8'h40, v); chk(v == 32'd500, "R12 write wins over increment", v, 500);
    look(rkey(7), "R12 after");
    do_cmd(3'd1, 3'b011, 7, 0, "R12 read counter");
    rd(8'h40, v); chk(v == 32'd501, "R12 increment after", v, 501);

    // R5 out-of-range row with key part enabled
    load(64'hFFFF, 64'd0, 32'd1, 32'h7777_7777, 32'd1);
    do_cmd(3'd0, 3'd0, 16, 0, "R5 row16");
    do_cmd(3'd0, 3'd0, 200, 0, "R5 row200");
    do_cmd(3'd4, 3'd0, 20, 3, "R5 fill");
    look(64'hFFFF, "R5 no entry");

    // R10 wildcard at row 12, priority sweep
    load(64'd0, {64{1'b1}}, 32'd1, 32'hFFFF_0012, 32'd0);
    do_cmd(3'd0, 3'd0, 12, 0, "R10 wildcard");
    for (int r = 0; r < 16; r++) look(rkey(r), "R10 priority");
    verify_all("R10 table");

    // R6 move up
    do_cmd(3'd2, 3'd0, 4, 3, "R6 up 4x3");
    do_cmd(3'd2, 3'd0, 0, 2, "R6 up at row0");
    verify_all("R6 table");
    // R7 move down
    do_cmd(3'd3, 3'd0, 8, 2, "R7 down 8x2");
    do_cmd(3'd3, 3'd0, 14, 3, "R7 down past end");
    verify_all("R7 table");
    // R8 fill
    load(64'hABCD_0000_0000_1111, 64'd0, 32'd3, 32'h0F0F_0F0F, 32'd42);
    do_cmd(3'd4, 3'd0, 13, 4, "R8 fill past end");
    do_cmd(3'd4, 3'd0, 2, 0, "R8 fill zero rows");
    do_cmd(3'd4, 3'b011, 0, 2, "R8 R9 fill counter only");
    verify_all("R8 table");
    for (int r = 0; r < 16; r++) look(rkey(r), "R10 final sweep");
    look(64'hABCD_0000_0000_1111, "R8 filled key");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule